// File: doc/BRIEF.md
# Slave Attention Request Controller

This block lives inside a sensor slave attached to a shared single-wire management bus. It decides the cycle on which the slave asks its bus transmitter to send an attention pulse to the master. It takes in several inputs:

- bus-idle status;
- bus-error and bus-reset detection pulses;
- one event pulse per sensor function, each with an enable bit;
- a strobe marking a master read of the device status register;
- a completion pulse from the transmitter.

It drives a one-cycle request to the transmitter and the status flags that the status register exposes.

Two kinds of attention exist. An attention for a function event is sent once. Further function attentions are then held back until the master reads the status register. This lets the master finish a single scan of all slaves and know that nothing more is pending. An attention for a bus error ignores that hold-back, so the master can always recover from a fault. It is dropped if a bus reset arrives before the bus first goes idle after the error. When both kinds are pending at the same idle opportunity, one request serves both.

Top module: `atn_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high), `attn_req`, every `stat_evt` bit and `stat_ber` are 0, and attention requests are not held back.
- R2: `attn_req` is high in a cycle only if `bus_idle` was high in the previous cycle. When the bus is idle, the transmitter is free and an attention is owed, `attn_req` rises on the next cycle.
- R3: `attn_req` is high for exactly one cycle. After a request, no new request starts until `tx_done` has been seen; a pending attention is issued on the cycle after the one that follows `tx_done`.
- R4: A function event `func_evt[i]` leads to an attention only while `func_en[i]` is 1. A disabled event still sets its status flag but raises no request.
- R5: After an attention that served an enabled function event, no further function-event attention is issued until `stat_rd` has been seen. The edge on which `stat_rd` is sampled ends the hold-back.
- R6: A pending bus error produces an attention even while function attentions are held back.
- R7: A `bus_rst` pulse cancels a bus-error attention that has not yet been sent. It also ends the function-attention hold-back.
- R8: When a bus error and an eligible function event are pending at the same opportunity, a single request is issued. The request clears the bus-error pending state and starts the hold-back.
- R9: `stat_rd` clears all status flags (`stat_evt`, `stat_ber`). A `func_evt[i]` or `bus_err` arriving on the same cycle leaves its flag set.
- R10: `stat_evt[i]` becomes 1 on the cycle after `func_evt[i]` is high. `stat_ber` becomes 1 on the cycle after `bus_err` is high. A bus reset does not clear either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| bus_idle | input | 1 | Bus is inactive; an attention may be sent |
| bus_err | input | 1 | Pulse: a bus error was detected |
| bus_rst | input | 1 | Pulse: a bus reset was detected |
| func_evt | input | N_FUNC | Pulse per function: event occurred |
| func_en | input | N_FUNC | Attention enable per function |
| stat_rd | input | 1 | Pulse: master read of the device status register |
| tx_done | input | 1 | Transmitter finished the last attention pulse |
| attn_req | output | 1 | One-cycle request to send an attention pulse |
| stat_evt | output | N_FUNC | Function event flags for the status register |
| stat_ber | output | 1 | Bus-error flag for the status register |

## Verification
The embedded properties check the following on every cycle:

- requests only follow an idle bus;
- each request lasts a single cycle;
- no request arrives while the transmitter still owes its done pulse;
- no request issues from the hold-back unless a bus error is pending;
- a bus reset empties the bus-error pending state;
- flags set and clear as the status register read demands.

The following can only be shown through the bench's scenarios, because each depends on a history of several events:

- a bus error breaking through the hold-back;
- cancellation by a bus reset between error and idle;
- one request serving a simultaneous bus error and function event;
- the hold-back ending on a status read that coincides with a new event.

// File: rtl/atn_pkg.sv
package atn_pkg;

    // Transmitter handshake state seen from the requester
    typedef enum logic [1:0] {
        TX_FREE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_WAIT  = 2'd2
    } tx_state_e;

    // Decision for one cycle: whether a request starts and why
    typedef struct packed {
        logic fire;
        logic by_func;
        logic by_ber;
    } atn_grant_t;

    function automatic atn_grant_t decide(input logic idle,
                                          input logic tx_free,
                                          input logic func_want,
                                          input logic held,
                                          input logic ber_pend);
        atn_grant_t g;
        g.by_func = func_want & ~held;
        g.by_ber  = ber_pend;
        g.fire    = idle & tx_free & (g.by_func | g.by_ber);
        return g;
    endfunction

endpackage

// File: rtl/atn_evt_track.sv
module atn_evt_track #(
    parameter int N_FUNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FUNC-1:0] func_evt,
    input  logic [N_FUNC-1:0] func_en,
    input  logic              stat_rd,
    output logic [N_FUNC-1:0] flags,
    output logic              func_want
);

    // One sticky flag per function; a same-cycle event beats the read clear
    for (genvar i = 0; i < N_FUNC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (func_evt[i])
                flags[i] <= 1'b1;
            else if (stat_rd)
                flags[i] <= 1'b0;
        end
    end

    assign func_want = |(flags & func_en);

    p_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && func_evt == '0) |=> (flags == '0));

    p_evt_sets_r10: assert property (@(posedge clk) disable iff (rst)
        (func_evt != '0) |=> ((flags & $past(func_evt)) == $past(func_evt)));

endmodule

// File: rtl/atn_ber_track.sv
module atn_ber_track (
    input  logic clk,
    input  logic rst,
    input  logic bus_err,
    input  logic bus_rst,
    input  logic stat_rd,
    input  logic sent,
    output logic ber_flag,
    output logic ber_pend
);

    // Status flag: visible to the master until read
    always_ff @(posedge clk) begin
        if (rst)
            ber_flag <= 1'b0;
        else if (bus_err)
            ber_flag <= 1'b1;
        else if (stat_rd)
            ber_flag <= 1'b0;
    end

    // Pending attention: cancelled by a bus reset, retired once sent
    always_ff @(posedge clk) begin
        if (rst || bus_rst)
            ber_pend <= 1'b0;
        else if (bus_err)
            ber_pend <= 1'b1;
        else if (sent)
            ber_pend <= 1'b0;
    end

    p_rst_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> !ber_pend);

    p_ber_flag_r10: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> ber_flag);

endmodule

// File: rtl/atn_issue.sv
module atn_issue
    import atn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_idle,
    input  logic bus_rst,
    input  logic stat_rd,
    input  logic tx_done,
    input  logic func_want,
    input  logic ber_pend,
    output logic sent,
    output logic attn_req
);

    tx_state_e  state;
    logic       held;
    atn_grant_t grant;

    always_comb grant = decide(bus_idle, state == TX_FREE, func_want, held, ber_pend);

    assign sent = grant.fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_FREE;
        end else begin
            unique case (state)
                TX_FREE:  if (grant.fire) state <= TX_PULSE;
                TX_PULSE: state <= tx_done ? TX_FREE : TX_WAIT;
                TX_WAIT:  if (tx_done) state <= TX_FREE;
                default:  state <= TX_FREE;
            endcase
        end
    end

    // Hold-back of function attentions; a request that served a function wins
    always_ff @(posedge clk) begin
        if (rst)
            held <= 1'b0;
        else if (grant.fire && grant.by_func)
            held <= 1'b1;
        else if (stat_rd || bus_rst)
            held <= 1'b0;
    end

    assign attn_req = (state == TX_PULSE);

    p_idle_only_r2: assert property (@(posedge clk) disable iff (rst)
        attn_req |-> $past(bus_idle));

    p_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        attn_req |=> !attn_req);

    p_wait_done_r3: assert property (@(posedge clk) disable iff (rst)
        (state == TX_WAIT && !tx_done) |=> !attn_req);

    p_held_r5: assert property (@(posedge clk) disable iff (rst)
        attn_req |-> $past(!held || ber_pend));

endmodule

// File: rtl/atn_ctrl.sv
module atn_ctrl #(
    parameter int N_FUNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_idle,
    input  logic              bus_err,
    input  logic              bus_rst,
    input  logic [N_FUNC-1:0] func_evt,
    input  logic [N_FUNC-1:0] func_en,
    input  logic              stat_rd,
    input  logic              tx_done,
    output logic              attn_req,
    output logic [N_FUNC-1:0] stat_evt,
    output logic              stat_ber
);

    logic func_want;
    logic ber_pend;
    logic sent;

    atn_evt_track #(.N_FUNC(N_FUNC)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .func_evt  (func_evt),
        .func_en   (func_en),
        .stat_rd   (stat_rd),
        .flags     (stat_evt),
        .func_want (func_want)
    );

    atn_ber_track u_ber (
        .clk      (clk),
        .rst      (rst),
        .bus_err  (bus_err),
        .bus_rst  (bus_rst),
        .stat_rd  (stat_rd),
        .sent     (sent),
        .ber_flag (stat_ber),
        .ber_pend (ber_pend)
    );

    atn_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .bus_idle  (bus_idle),
        .bus_rst   (bus_rst),
        .stat_rd   (stat_rd),
        .tx_done   (tx_done),
        .func_want (func_want),
        .ber_pend  (ber_pend),
        .sent      (sent),
        .attn_req  (attn_req)
    );

endmodule

// File: tb/atn_ctrl_bench.sv
module atn_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst, bus_idle, bus_err, bus_rst, stat_rd, tx_done;
    logic [N-1:0] func_evt, func_en;
    logic attn_req, stat_ber;
    logic [N-1:0] stat_evt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    logic m_req, m_busy, m_berf, m_berp, m_sup;
    logic [N-1:0] m_flg;

    always #(CLK_PERIOD/2) clk = ~clk;

    atn_ctrl #(.N_FUNC(N)) u_atn_ctrl (
        .clk(clk), .rst(rst), .bus_idle(bus_idle), .bus_err(bus_err),
        .bus_rst(bus_rst), .func_evt(func_evt), .func_en(func_en),
        .stat_rd(stat_rd), .tx_done(tx_done), .attn_req(attn_req),
        .stat_evt(stat_evt), .stat_ber(stat_ber)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_req(input string tag, input logic exp);
        check(attn_req === exp, tag, int'(attn_req), int'(exp));
    endtask

    // One clock: advance the reference, then sample at the falling edge
    task automatic tick();
        logic fsel, fire;
        logic n_req, n_busy, n_berf, n_berp, n_sup;
        logic [N-1:0] n_flg;
        fsel = (|(m_flg & func_en)) & ~m_sup;
        fire = bus_idle & ~m_busy & (m_berp | fsel);
        n_req  = fire;
        n_busy = fire ? 1'b1 : (tx_done ? 1'b0 : m_busy);
        n_flg  = func_evt | (stat_rd ? '0 : m_flg);
        n_berf = bus_err | (stat_rd ? 1'b0 : m_berf);
        n_berp = bus_rst ? 1'b0 : (bus_err ? 1'b1 : (fire ? 1'b0 : m_berp));
        n_sup  = (fire & fsel) ? 1'b1 : ((stat_rd | bus_rst) ? 1'b0 : m_sup);
        if (rst) begin
            n_req = 0; n_busy = 0; n_flg = '0; n_berf = 0; n_berp = 0; n_sup = 0;
        end
        @(negedge clk);
        m_req = n_req; m_busy = n_busy; m_flg = n_flg;
        m_berf = n_berf; m_berp = n_berp; m_sup = n_sup;
    endtask

    task automatic quiet();
        func_evt = '0; bus_err = 0; bus_rst = 0; stat_rd = 0; tx_done = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_idle = 0; func_en = '0; quiet();
        m_req = 0; m_busy = 0; m_flg = '0; m_berf = 0; m_berp = 0; m_sup = 0;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;
        tick();
        // R1: reset state
        chk_req("R1 attn_req", 1'b0);
        check(stat_evt == '0, "R1 stat_evt", int'(stat_evt), 0);
        check(stat_ber == 1'b0, "R1 stat_ber", int'(stat_ber), 0);

        // R4 / R10: disabled event sets flag, no request
        bus_idle = 1; func_evt = 2'b01; tick(); quiet();
        check(stat_evt == 2'b01, "R10 stat_evt set", int'(stat_evt), 1);
        for (int k = 0; k < 3; k++) begin tick(); chk_req("R4 disabled event", 1'b0); end

        // R2: enabled but bus busy, then idle
        bus_idle = 0; func_en = 2'b11; func_evt = 2'b10; tick(); quiet();
        tick(); chk_req("R2 bus active", 1'b0);
        bus_idle = 1; tick(); chk_req("R2 idle request", 1'b1);
        tick(); chk_req("R3 single cycle", 1'b0);
        bus_err = 1; tick(); quiet(); chk_req("R3 wait for done", 1'b0);
        tick(); chk_req("R3 wait for done", 1'b0);
        tx_done = 1; tick(); quiet(); chk_req("R3 done cycle", 1'b0);
        tick(); chk_req("R6 error bypasses hold-back", 1'b1);
        check(stat_ber == 1'b1, "R10 stat_ber set", int'(stat_ber), 1);
        tx_done = 1; tick(); quiet();
        for (int k = 0; k < 2; k++) begin tick(); chk_req("R5 held back", 1'b0); end

        // R9: read with a coinciding event
        stat_rd = 1; func_evt = 2'b01; tick(); quiet();
        check(stat_evt == 2'b01, "R9 read keeps new event", int'(stat_evt), 1);
        check(stat_ber == 1'b0, "R9 read clears ber flag", int'(stat_ber), 0);
        tick(); chk_req("R5 released by read", 1'b1);
        tx_done = 1; tick(); quiet();

        // R7: bus reset between error and idle
        stat_rd = 1; tick(); quiet();
        bus_idle = 0; bus_err = 1; tick(); quiet();
        bus_rst = 1; tick(); quiet();
        bus_idle = 1;
        for (int k = 0; k < 3; k++) begin tick(); chk_req("R7 error cancelled", 1'b0); end
        check(stat_ber == 1'b1, "R10 flag survives bus reset", int'(stat_ber), 1);

        // R7: bus reset ends the hold-back
        bus_idle = 0; func_evt = 2'b10; tick(); quiet();
        bus_idle = 1; tick(); chk_req("R7 setup request", 1'b1);
        tx_done = 1; tick(); quiet();
        tick(); chk_req("R7 held before reset", 1'b0);
        bus_rst = 1; tick(); quiet(); chk_req("R7 reset cycle", 1'b0);
        tick(); chk_req("R7 hold-back cleared", 1'b1);
        tx_done = 1; tick(); quiet();

        // R8: simultaneous error and event
        stat_rd = 1; tick(); quiet();
        bus_idle = 0; func_evt = 2'b01; bus_err = 1; tick(); quiet();
        bus_idle = 1; tick(); chk_req("R8 single request", 1'b1);
        tick(); chk_req("R8 pulse ends", 1'b0);
        tx_done = 1; tick(); quiet();
        for (int k = 0; k < 3; k++) begin tick(); chk_req("R8 both retired", 1'b0); end

        // Sweep: mixed stimulus against the reference
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] r;
            r = $urandom;
            bus_idle = (r[2:0] != 3'd0);
            func_evt = (r[6:3] == 4'd0) ? r[8:7] : '0;
            func_en  = (c % 512 < 256) ? 2'b11 : r[10:9];
            bus_err  = (r[15:11] == 5'd0);
            bus_rst  = (r[20:16] == 5'd0);
            stat_rd  = (r[24:21] == 4'd0);
            tx_done  = (r[26:25] == 2'd0);
            tick();
            chk_req("R3 sweep attn_req", m_req);
            check(stat_evt == m_flg, "R10 sweep stat_evt", int'(stat_evt), int'(m_flg));
            check(stat_ber == m_berf, "R9 sweep stat_ber", int'(stat_ber), int'(m_berf));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule